// File: doc/BRIEF.md
# On-Screen Display Raster Character Address Generator

This block runs on the dot clock of an on-screen display overlay. It watches the horizontal and vertical sync pulses, counts lines from each vertical sync and dot clocks from each horizontal sync, and finds the rectangle where the character window lies. Inside that rectangle it reports, for every dot clock, which display-memory cell is on screen (row and column), which line of the character font applies, and which dot within that font line applies. A downstream font lookup and pixel mixer use these values. The block does not hold the font or the display memory.

The window is a grid of 12 rows by 24 columns of cells. Each cell is 12 dots wide and 18 lines tall. Each row can be magnified on its own by a 2-bit size code, which repeats every dot and every font line two or three times. An enlarged row pushes every row below it down by its extra height. Horizontally, the window keeps its normal-size width, so an enlarged row shows fewer cells and the rest of that row is cut off at the right edge.

Top module: `osd_raster_addr`

## Requirements
- R1: After reset, and until a vertical sync leading edge and then a horizontal sync leading edge have been seen, `active_o` is 0.
- R2: Lines are counted from the vertical sync leading edge. The interval up to the first horizontal sync leading edge is line 0, and each horizontal sync leading edge adds one. The first window line is line `vstart_i`, and no earlier line is active.
- R3: Dots are counted from the horizontal sync leading edge. The first clock after the clock that samples the edge is dot position 0. The first window dot is position `hstart_i`, and no earlier position is active.
- R4: In a normal-size row, `dot_o` runs from 0 to 11 with one step per clock, and `ram_col_o` then advances by one. `font_line_o` runs from 0 to 17 with one step per line, and `ram_row_o` then advances by one.
- R5: The size code of row r is `row_size_i[2r+1:2r]`. Code 00 and code 11 mean normal size, 01 means double size and 10 means triple size.
- R6: In a row magnified by factor s (2 or 3), each value of `dot_o` is held for s clocks and each value of `font_line_o` is held for s lines.
- R7: Each row occupies 18·s lines, where s is its own factor. A row therefore starts after the total height of all rows above it.
- R8: On every line, the active span is 288 dots wide (24 × 12) whatever the row's size. Cells of an enlarged row that would start beyond that width are not active.
- R9: When `active_o` is 0, `ram_row_o`, `ram_col_o`, `font_line_o` and `dot_o` are all 0.
- R10: A vertical sync leading edge restarts the line count and the row sequence at any time, even in mid-frame. A horizontal sync leading edge restarts the dot count at any time, even in mid-line.
- R11: After the last line of row 11, no line is active until the next vertical sync leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync; leading edge is rising by default |
| vsync_i | input | 1 | Vertical sync; leading edge is rising by default |
| vstart_i | input | 6 | Vertical window start, in lines after vertical sync |
| hstart_i | input | 6 | Horizontal window start, in dot clocks after horizontal sync |
| row_size_i | input | 24 | Two-bit size code for each of the 12 rows |
| active_o | output | 1 | The current dot lies in a displayed cell |
| ram_row_o | output | 4 | Display-memory row of the current cell |
| ram_col_o | output | 5 | Display-memory column of the current cell |
| font_line_o | output | 5 | Font line within the cell, 0 to 17 |
| dot_o | output | 4 | Dot within the font line, 0 to 11 |

## Verification
All outputs come from registered counters through gating logic only. A sync leading edge that the dot clock samples at edge k therefore shows in the outputs in the cycle that follows edge k, and that cycle is dot position 0 (or line N for the vertical count). The bench drives sync on falling clock edges and samples on falling clock edges. It numbers dot positions from the first falling edge after the clock that samples the hsync rise, and numbers lines by the hsync pulses it has issued since the last vsync. So every expected value from its arithmetic model lines up with the cycle in which the design's output is due. Short lines that are not checked move the vertical count quickly. Probed lines are long enough to cover the whole window plus the dots on either side of it.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

   typedef logic [1:0] size_code_t;

   // magnification factor for a row size code: 01 -> 2, 10 -> 3, 00/11 -> 1
   function automatic logic [1:0] size_factor(input size_code_t code);
      case (code)
         2'b01:   return 2'd2;
         2'b10:   return 2'd3;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/osd_sync_lead.sv
module osd_sync_lead #(
   parameter bit LEAD_RISE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   output logic lead_o
);

   logic sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= LEAD_RISE;
      else         sync_q <= sync_i;
   end

   generate
      if (LEAD_RISE) begin : g_rise
         assign lead_o = sync_i & ~sync_q;
      end else begin : g_fall
         assign lead_o = ~sync_i & sync_q;
      end
   endgenerate

endmodule

// File: rtl/osd_vert_track.sv
module osd_vert_track
   import osd_raster_pkg::*;
#(
   parameter int ROWS    = 12,
   parameter int CELL_H  = 18,
   parameter int START_W = 6
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        vs_lead_i,
   input  logic                        hs_lead_i,
   input  logic [START_W-1:0]          vstart_i,
   input  logic [2*ROWS-1:0]           row_size_i,
   output logic                        vwin_o,
   output logic [$clog2(ROWS+1)-1:0]   row_o,
   output logic [$clog2(CELL_H)-1:0]   fline_o,
   output logic [1:0]                  scale_o
);

   localparam int RW = $clog2(ROWS+1);
   localparam int FW = $clog2(CELL_H);
   localparam int SW = START_W + 1;
   localparam logic [RW-1:0] ROW_END = RW'(ROWS);
   localparam logic [FW-1:0] FL_LAST = FW'(CELL_H - 1);
   localparam logic [SW-1:0] VMAX    = '1;

   logic [SW-1:0] vcnt;
   logic [RW-1:0] vrow;
   logic [FW-1:0] fline;
   logic [1:0]    vrep;
   logic [1:0]    cur_scale;
   logic [1:0]    scale_tab [ROWS];

   generate
      for (genvar g = 0; g < ROWS; g++) begin : g_row
         assign scale_tab[g] = size_factor(row_size_i[2*g +: 2]);
      end
   endgenerate

   always_comb begin
      cur_scale = 2'd1;
      for (int r = 0; r < ROWS; r++) begin
         if (vrow == RW'(r)) cur_scale = scale_tab[r];
      end
   end

   assign vwin_o  = (vcnt >= {1'b0, vstart_i}) && (vrow < ROW_END);
   assign row_o   = vrow;
   assign fline_o = fline;
   assign scale_o = cur_scale;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vcnt  <= VMAX;
         vrow  <= ROW_END;
         fline <= '0;
         vrep  <= '0;
      end else if (vs_lead_i) begin
         vcnt  <= '0;
         vrow  <= '0;
         fline <= '0;
         vrep  <= '0;
      end else if (hs_lead_i) begin
         if (vcnt != VMAX) vcnt <= vcnt + 1'b1;
         if (vwin_o) begin
            if (vrep == 2'(cur_scale - 2'd1)) begin
               vrep <= '0;
               if (fline == FL_LAST) begin
                  fline <= '0;
                  vrow  <= vrow + 1'b1;
               end else begin
                  fline <= fline + 1'b1;
               end
            end else begin
               vrep <= vrep + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/osd_horz_track.sv
module osd_horz_track #(
   parameter int COLS    = 24,
   parameter int CELL_W  = 12,
   parameter int START_W = 6
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        hs_lead_i,
   input  logic [START_W-1:0]          hstart_i,
   input  logic [1:0]                  scale_i,
   output logic                        hwin_o,
   output logic [$clog2(COLS+1)-1:0]   col_o,
   output logic [$clog2(CELL_W)-1:0]   dot_o
);

   localparam int WIN_W = COLS * CELL_W;
   localparam int XW    = $clog2(WIN_W + 1);
   localparam int CW    = $clog2(COLS + 1);
   localparam int DW    = $clog2(CELL_W);
   localparam int HW    = START_W + 1;
   localparam logic [XW-1:0] WIN_END  = XW'(WIN_W);
   localparam logic [DW-1:0] DOT_LAST = DW'(CELL_W - 1);
   localparam logic [HW-1:0] HMAX     = '1;

   logic [HW-1:0] hcnt;
   logic [XW-1:0] xcnt;
   logic [CW-1:0] col;
   logic [DW-1:0] dot;
   logic [1:0]    hrep;

   assign hwin_o = (hcnt >= {1'b0, hstart_i}) && (xcnt < WIN_END);
   assign col_o  = col;
   assign dot_o  = dot;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hcnt <= HMAX;
         xcnt <= WIN_END;
         col  <= '0;
         dot  <= '0;
         hrep <= '0;
      end else if (hs_lead_i) begin
         hcnt <= '0;
         xcnt <= '0;
         col  <= '0;
         dot  <= '0;
         hrep <= '0;
      end else begin
         if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
         if (hwin_o) begin
            xcnt <= xcnt + 1'b1;
            if (hrep == 2'(scale_i - 2'd1)) begin
               hrep <= '0;
               if (dot == DOT_LAST) begin
                  dot <= '0;
                  col <= col + 1'b1;
               end else begin
                  dot <= dot + 1'b1;
               end
            end else begin
               hrep <= hrep + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/osd_raster_addr.sv
module osd_raster_addr #(
   parameter int ROWS      = 12,
   parameter int COLS      = 24,
   parameter int CELL_W    = 12,
   parameter int CELL_H    = 18,
   parameter int START_W   = 6,
   parameter bit SYNC_RISE = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        hsync_i,
   input  logic                        vsync_i,
   input  logic [START_W-1:0]          vstart_i,
   input  logic [START_W-1:0]          hstart_i,
   input  logic [2*ROWS-1:0]           row_size_i,
   output logic                        active_o,
   output logic [$clog2(ROWS+1)-1:0]   ram_row_o,
   output logic [$clog2(COLS+1)-1:0]   ram_col_o,
   output logic [$clog2(CELL_H)-1:0]   font_line_o,
   output logic [$clog2(CELL_W)-1:0]   dot_o
);

   localparam int RW = $clog2(ROWS + 1);
   localparam int CW = $clog2(COLS + 1);
   localparam int FW = $clog2(CELL_H);
   localparam int DW = $clog2(CELL_W);

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_grid
         $error("osd_raster_addr: grid needs at least one row and column");
      end
      if (CELL_W < 2 || CELL_H < 2) begin : g_bad_cell
         $error("osd_raster_addr: cell must be at least 2x2");
      end
      if (START_W < 1) begin : g_bad_start
         $error("osd_raster_addr: start field needs at least one bit");
      end
   endgenerate

   logic          hs_lead, vs_lead;
   logic          vwin, hwin;
   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic [FW-1:0] fline;
   logic [DW-1:0] dot;
   logic [1:0]    scale;

   osd_sync_lead #(.LEAD_RISE(SYNC_RISE)) u_hs_lead (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(hsync_i), .lead_o(hs_lead)
   );

   osd_sync_lead #(.LEAD_RISE(SYNC_RISE)) u_vs_lead (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(vsync_i), .lead_o(vs_lead)
   );

   osd_vert_track #(.ROWS(ROWS), .CELL_H(CELL_H), .START_W(START_W)) u_vert (
      .clk_i(clk_i), .rst_ni(rst_ni), .vs_lead_i(vs_lead), .hs_lead_i(hs_lead),
      .vstart_i(vstart_i), .row_size_i(row_size_i),
      .vwin_o(vwin), .row_o(row), .fline_o(fline), .scale_o(scale)
   );

   osd_horz_track #(.COLS(COLS), .CELL_W(CELL_W), .START_W(START_W)) u_horz (
      .clk_i(clk_i), .rst_ni(rst_ni), .hs_lead_i(hs_lead), .hstart_i(hstart_i),
      .scale_i(scale), .hwin_o(hwin), .col_o(col), .dot_o(dot)
   );

   assign active_o    = vwin & hwin;
   assign ram_row_o   = active_o ? row   : '0;
   assign ram_col_o   = active_o ? col   : '0;
   assign font_line_o = active_o ? fline : '0;
   assign dot_o       = active_o ? dot   : '0;

endmodule

// File: rtl/osd_raster_addr_chk.sv
module osd_raster_addr_chk #(
   parameter int ROWS      = 12,
   parameter int COLS      = 24,
   parameter int CELL_W    = 12,
   parameter int CELL_H    = 18,
   parameter int START_W   = 6,
   parameter bit SYNC_RISE = 1'b1
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        hsync_i,
   input logic                        vsync_i,
   input logic [START_W-1:0]          vstart_i,
   input logic [START_W-1:0]          hstart_i,
   input logic                        active_o,
   input logic [$clog2(ROWS+1)-1:0]   ram_row_o,
   input logic [$clog2(COLS+1)-1:0]   ram_col_o,
   input logic [$clog2(CELL_H)-1:0]   font_line_o,
   input logic [$clog2(CELL_W)-1:0]   dot_o
);

   logic hs_q, vs_q, hs_lead_c, vs_lead_c;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_q <= SYNC_RISE;
         vs_q <= SYNC_RISE;
      end else begin
         hs_q <= hsync_i;
         vs_q <= vsync_i;
      end
   end

   assign hs_lead_c = SYNC_RISE ? (hsync_i & ~hs_q) : (~hsync_i & hs_q);
   assign vs_lead_c = SYNC_RISE ? (vsync_i & ~vs_q) : (~vsync_i & vs_q);

   // R9
   idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_o |-> (ram_row_o == '0 && ram_col_o == '0 && font_line_o == '0 && dot_o == '0));

   // R4
   addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o |-> (int'(ram_row_o) < ROWS && int'(ram_col_o) < COLS &&
                    int'(font_line_o) < CELL_H && int'(dot_o) < CELL_W));

   // R3
   hstart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_lead_c |=> (hstart_i == '0 || !active_o));

   // R2
   vstart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vs_lead_c |=> (vstart_i == '0 || !active_o));

   // R4
   dot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && $past(active_o) && !$past(hs_lead_c) && !$past(vs_lead_c)) |->
         ($stable(ram_row_o) && $stable(font_line_o) &&
          (($stable(dot_o) && $stable(ram_col_o)) ||
           (dot_o == $past(dot_o) + 1'b1 && $stable(ram_col_o)) ||
           (dot_o == '0 && ram_col_o == $past(ram_col_o) + 1'b1))));

endmodule

bind osd_raster_addr osd_raster_addr_chk #(
   .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .CELL_H(CELL_H),
   .START_W(START_W), .SYNC_RISE(SYNC_RISE)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
   .vstart_i(vstart_i), .hstart_i(hstart_i), .active_o(active_o),
   .ram_row_o(ram_row_o), .ram_col_o(ram_col_o),
   .font_line_o(font_line_o), .dot_o(dot_o)
);

// File: tb/sim_osd_raster_addr.sv
module sim_osd_raster_addr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0;
   logic        vsync = 1'b0;
   logic [5:0]  vstart = '0;
   logic [5:0]  hstart = '0;
   logic [23:0] sizes = '0;
   logic        active;
   logic [3:0]  row;
   logic [4:0]  col;
   logic [4:0]  fline;
   logic [3:0]  dot;

   int n_vec = 0;
   int n_bad = 0;
   int line_no = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   osd_raster_addr u0 (
      .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .vstart_i(vstart), .hstart_i(hstart), .row_size_i(sizes),
      .active_o(active), .ram_row_o(row), .ram_col_o(col),
      .font_line_o(fline), .dot_o(dot)
   );

   function automatic int sf(int r);
      case (sizes[2*r +: 2])
         2'b01:   return 2;
         2'b10:   return 3;
         default: return 1;
      endcase
   endfunction

   // arithmetic model of the window for line L, dot position t
   function automatic void model(input int L, input int t, output bit a,
                                 output int r, output int c, output int f, output int d);
      int y, x, s, rr;
      a = 0; r = 0; c = 0; f = 0; d = 0;
      if (L < int'(vstart) || t < int'(hstart)) return;
      y = L - int'(vstart);
      rr = 0;
      while (rr < 12 && y >= 18 * sf(rr)) begin
         y -= 18 * sf(rr);
         rr++;
      end
      if (rr >= 12) return;
      x = t - int'(hstart);
      if (x >= 288) return;
      s = sf(rr);
      a = 1; r = rr; f = y / s; c = x / (12 * s); d = (x % (12 * s)) / s;
   endfunction

   task automatic check_px(input int L, input int t, input string req);
      bit ea; int er, ec, ef, ed;
      model(L, t, ea, er, ec, ef, ed);
      n_vec++;
      if (active !== ea || int'(row) != er || int'(col) != ec ||
          int'(fline) != ef || int'(dot) != ed) begin
         n_bad++;
         $display("FAIL %s line %0d pos %0d: got act=%0d row=%0d col=%0d fl=%0d dot=%0d exp act=%0d row=%0d col=%0d fl=%0d dot=%0d",
                  req, L, t, active, row, col, fline, dot, ea, er, ec, ef, ed);
      end
   endtask

   task automatic do_vsync();
      @(negedge clk) vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
      line_no = 0;
   endtask

   task automatic do_line(input int len, input bit chk, input string req);
      @(negedge clk) hsync = 1'b1;
      line_no++;
      @(negedge clk) hsync = 1'b0;
      for (int t = 0; t < len; t++) begin
         if (chk) check_px(line_no, t, req);
         @(negedge clk);
      end
   endtask

   // R1: nothing active after reset before any sync
   task automatic t_reset();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         n_vec++;
         if (active !== 1'b0 || row != 0 || col != 0 || fline != 0 || dot != 0) begin
            n_bad++;
            $display("FAIL R1 cycle %0d: got act=%0d row=%0d col=%0d exp act=0 all zero",
                     i, active, row, col);
         end
      end
   endtask

   // R2 R3 R4 R9 R11: all normal size
   task automatic t_normal();
      int len;
      sizes = '0; vstart = 6'd3; hstart = 6'd5;
      len = 5 + 295;
      do_vsync();
      for (int L = 1; L <= 221; L++) begin
         if (L == 2)                      do_line(len, 1, "R2");
         else if (L == 3)                 do_line(len, 1, "R3 R9");
         else if (L inside {20, 21, 218}) do_line(len, 1, "R4");
         else if (L == 219)               do_line(len, 1, "R11");
         else                             do_line(1, 0, "");
      end
   endtask

   // R5 R6 R7 R8: row0 double, row1 triple, row2 code 11, rest code 00
   task automatic t_mixed();
      int len;
      sizes = 24'h000039; vstart = 6'd1; hstart = 6'd0;
      len = 295;
      do_vsync();
      for (int L = 1; L <= 273; L++) begin
         if (L inside {1, 2, 3, 36})      do_line(len, 1, "R6 R8");
         else if (L inside {37, 38, 90})  do_line(len, 1, "R7 R6");
         else if (L inside {91, 109})     do_line(len, 1, "R5 R7");
         else if (L == 272)               do_line(len, 1, "R11");
         else                             do_line(1, 0, "");
      end
   endtask

   // R2 R3 at the largest start values
   task automatic t_maxstart();
      int len;
      sizes = 24'h800000; vstart = 6'd63; hstart = 6'd63;
      len = 63 + 295;
      do_vsync();
      for (int L = 1; L <= 64; L++) begin
         if (L >= 62) do_line(len, 1, "R2 R3");
         else         do_line(1, 0, "");
      end
   endtask

   // R10: vsync in mid-frame and hsync in mid-line restart the counts
   task automatic t_restart();
      sizes = 24'h000004; vstart = 6'd2; hstart = 6'd4;
      do_vsync();
      for (int L = 1; L <= 30; L++) do_line(1, 0, "");
      do_line(40, 1, "R10");
      do_vsync();
      do_line(120, 1, "R10");
      do_line(150, 1, "R10");
      do_line(299, 1, "R10");
      do_line(299, 1, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_mixed();
      t_maxstart();
      t_restart();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule